// File: doc/BRIEF.md
# Edge-Qualified Trigger Action Controller

This block watches one external trigger line and turns its transitions into three kinds of one-cycle request pulses for a neighbouring timer: start, stop and clear. Each request kind has its own 2-bit mode field. The field says whether that request ignores the trigger, fires on a rising transition, fires on a falling transition, or fires on both. The trigger is asynchronous to the block clock. It first passes through a two-flop synchroniser. A transition is found by comparing the newest synchronised sample with the one before it.

The three mode fields sit at fixed positions in one 32-bit control word that the block receives as a whole. All other bits of that word are ignored. The decoders are independent, so a single transition can raise several requests in the same cycle. When start and stop fire together, both are passed on and the receiving timer decides which one wins.

Top module: `trig_action_ctrl`

## Requirements
- R1: The start mode is taken from control-word bits [19:18], and start_req fires only on transitions that this field qualifies.
- R2: The stop mode is taken from control-word bits [23:22], and stop_req fires only on transitions that this field qualifies.
- R3: The clear mode is taken from control-word bits [27:26], and clear_req fires only on transitions that this field qualifies.
- R4: Every mode field uses the same encoding: 0 = never, 1 = low-to-high trigger transition, 2 = high-to-low transition, 3 = either transition.
- R5: Each qualifying transition produces exactly one request pulse, one clock cycle long. A trigger that toggles on consecutive cycles gives one pulse per toggle.
- R6: When one transition qualifies for both start and stop, start_req and stop_req are high in the same cycle.
- R7: While reset is asserted, and after it is released, no request is produced. This includes the case where the trigger level is held high through reset; that level is only a starting sample, not a transition.
- R8: Control-word bits outside the three mode fields have no effect on any request.
- R9: A trigger change that is set up before rising clock edge k produces its request in the cycle that follows rising edge k+2. The request is low after edges k and k+1, and low again after edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_in | input | 1 | External trigger line, asynchronous to clk |
| ctrl_word | input | 32 | Control word holding the start, stop and clear mode fields |
| start_req | output | 1 | One-cycle start request |
| stop_req | output | 1 | One-cycle stop request |
| clear_req | output | 1 | One-cycle clear request |

## Verification
The assertions check on every cycle the following:
- every request follows a detected transition;
- a request never appears when its mode field was 0;
- a request only appears when its own field was nonzero;
- rising and falling detections never repeat back to back;
- a start/stop pair qualified by one transition appears together;
- the trigger changed exactly three edges before any start pulse.

Some behaviour only the bench scenarios can show:
- a qualified transition actually produces a pulse;
- the per-encoding outcome for rising and falling transitions;
- that the bits outside the fields are ignored;
- that the trigger level held through reset is silent.

// File: rtl/trig_ctl_pkg.sv
package trig_ctl_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  localparam int CTRL_W   = 32;
  localparam int MODE_W   = 2;
  localparam int N_ACT    = 3;
  localparam int ACT_BASE = 18;
  localparam int ACT_STEP = 4;

  localparam int ACT_START = 0;
  localparam int ACT_STOP  = 1;
  localparam int ACT_CLEAR = 2;

  // Low bit of each action's mode field in the control word.
  function automatic int act_lsb(input int idx);
    return ACT_BASE + ACT_STEP * idx;
  endfunction

  localparam int START_LSB = ACT_BASE;
  localparam int STOP_LSB  = ACT_BASE + ACT_STEP;
  localparam int CLEAR_LSB = ACT_BASE + 2 * ACT_STEP;

  localparam logic [CTRL_W-1:0] FIELD_MASK =
    (32'h3 << START_LSB) | (32'h3 << STOP_LSB) | (32'h3 << CLEAR_LSB);

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] rst_q;
  logic [STAGES-1:0] rst_d;

  always_comb begin
    rst_d = {rst_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q <= '0;
    end else begin
      rst_q <= rst_d;
    end
  end

  assign rst_n_o = rst_q[STAGES-1];

endmodule

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic [STAGES:0]   vld_q,  vld_d;   // marks which stages hold real samples

  always_comb begin
    sync_d[0] = din;
    for (int k = 1; k < STAGES; k++) begin
      sync_d[k] = sync_q[k-1];
    end
    prev_d = sync_q[LAST];
    vld_d  = {vld_q[STAGES-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      vld_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      vld_q  <= vld_d;
    end
  end

  // An edge is only reported once the previous-sample flop holds a real value.
  assign rise_o = vld_q[STAGES] &  sync_q[LAST] & ~prev_q;
  assign fall_o = vld_q[STAGES] & ~sync_q[LAST] &  prev_q;

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o) else $error("rise detected twice in a row"); // R5
  AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o) else $error("fall detected twice in a row"); // R5

endmodule

// File: rtl/trig_edge_qual.sv
module trig_edge_qual
  import trig_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  edge_sel_e mode_i,
  input  logic      rise_i,
  input  logic      fall_i,
  output logic      req_o
);

  logic req_d, req_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: req_d = rise_i;
      EDGE_FALL: req_d = fall_i;
      EDGE_ANY:  req_d = rise_i | fall_i;
      default:   req_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  AST_REQ_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $past(rise_i || fall_i)) else $error("request without edge"); // R5
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == EDGE_OFF) |-> !req_o) else $error("request with mode off"); // R4

endmodule

// File: rtl/trig_action_ctrl.sv
module trig_action_ctrl
  import trig_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              start_req,
  output logic              stop_req,
  output logic              clear_req
);

  logic             rst_n_int;
  logic             rise, fall;
  logic [N_ACT-1:0] req;
  logic             ctrl_unused;

  // Bits outside the mode fields are deliberately left undecoded.
  assign ctrl_unused = ^(ctrl_word & ~FIELD_MASK);

  trig_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  trig_edge_detect #(.STAGES(SYNC_STAGES)) u_det (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .din    (trig_in),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar i = 0; i < N_ACT; i++) begin : g_act
    localparam int LSB = act_lsb(i);
    trig_edge_qual u_qual (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .mode_i (edge_sel_e'(ctrl_word[LSB +: MODE_W])),
      .rise_i (rise),
      .fall_i (fall),
      .req_o  (req[i])
    );
  end

  assign start_req = req[ACT_START];
  assign stop_req  = req[ACT_STOP];
  assign clear_req = req[ACT_CLEAR];

  AST_START_FIELD: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_req |-> ($past(ctrl_word[START_LSB +: 2]) != 2'd0)) else $error("start field"); // R1
  AST_STOP_FIELD: assert property (@(posedge clk) disable iff (!rst_n_int)
    stop_req |-> ($past(ctrl_word[STOP_LSB +: 2]) != 2'd0)) else $error("stop field"); // R2
  AST_CLEAR_FIELD: assert property (@(posedge clk) disable iff (!rst_n_int)
    clear_req |-> ($past(ctrl_word[CLEAR_LSB +: 2]) != 2'd0)) else $error("clear field"); // R3
  AST_START_STOP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($past(rise) && $past(ctrl_word[START_LSB +: 2]) == 2'd1
                 && $past(ctrl_word[STOP_LSB +: 2]) == 2'd1) |-> (start_req && stop_req))
    else $error("start/stop split"); // R6

  if (SYNC_STAGES == 2) begin : g_lat_chk
    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_int)
      start_req |-> ($past(trig_in, 3) != $past(trig_in, 4))) else $error("latency"); // R9
  end

endmodule

// File: tb/sim_trig_action_ctrl.sv
module sim_trig_action_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig;
  logic [31:0] ctrl;
  logic        start_req, stop_req, clear_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  trig_action_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig),
    .ctrl_word (ctrl),
    .start_req (start_req),
    .stop_req  (stop_req),
    .clear_req (clear_req)
  );

  // {start mode, stop mode, clear mode, falling edge, junk in other bits, expect {start,stop,clear}}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 3'b100},  // R1 rising
    {2'd1, 2'd0, 2'd0, 1'b1, 1'b0, 3'b000},  // R1 rising mode ignores fall
    {2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 3'b100},  // R1 falling
    {2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 3'b010},  // R2 rising
    {2'd0, 2'd2, 2'd0, 1'b0, 1'b0, 3'b000},  // R2 falling mode ignores rise
    {2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 3'b001},  // R3 either, rising
    {2'd0, 2'd0, 2'd3, 1'b1, 1'b0, 3'b001},  // R3 either, falling
    {2'd3, 2'd3, 2'd0, 1'b0, 1'b0, 3'b110},  // R6 start and stop together
    {2'd2, 2'd1, 2'd1, 1'b0, 1'b0, 3'b011},  // R4 mixed, rising
    {2'd2, 2'd1, 2'd1, 1'b1, 1'b0, 3'b100},  // R4 mixed, falling
    {2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'b000},  // R4 all off, rising
    {2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 3'b000},  // R8 all off, junk set
    {2'd3, 2'd3, 2'd3, 1'b0, 1'b1, 3'b111},  // R8 all either, junk set
    {2'd1, 2'd2, 2'd3, 1'b1, 1'b1, 3'b011}   // R8 mixed, junk set
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] make_word(input logic [1:0] st, input logic [1:0] sp,
                                            input logic [1:0] cl, input logic junk);
    logic [31:0] w;
    w = junk ? 32'hF333_FFFF : 32'h0;
    w[19:18] = st;
    w[23:22] = sp;
    w[27:26] = cl;
    return w;
  endfunction

  task automatic count_pulses(input int n, output int cs, output int cp, output int cc);
    cs = 0; cp = 0; cc = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cs += int'(start_req);
      cp += int'(stop_req);
      cc += int'(clear_req);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int cs, cp, cc;
    // R7: trigger held high through reset with every mode on either edge
    rst_n = 1'b0;
    trig  = 1'b1;
    ctrl  = make_word(2'd3, 2'd3, 2'd3, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 start in reset", int'(start_req), 0);
    check("R7 stop in reset",  int'(stop_req),  0);
    check("R7 clear in reset", int'(clear_req), 0);
    rst_n = 1'b1;
    count_pulses(10, cs, cp, cc);
    check("R7 start after release", cs, 0);
    check("R7 stop after release",  cp, 0);
    check("R7 clear after release", cc, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [10:0] e;
      e = VEC[v];
      ctrl = 32'h0;
      @(negedge clk);
      trig = e[4];
      repeat (5) @(negedge clk);
      ctrl = make_word(e[10:9], e[8:7], e[6:5], e[3]);
      @(negedge clk);
      trig = ~e[4];
      count_pulses(6, cs, cp, cc);
      check($sformatf("R1 vec%0d start", v), cs, int'(e[2]));
      check($sformatf("R2 vec%0d stop",  v), cp, int'(e[1]));
      check($sformatf("R3 vec%0d clear", v), cc, int'(e[0]));
    end

    // R9: latency of a rising start request
    ctrl = 32'h0;
    @(negedge clk);
    trig = 1'b0;
    repeat (5) @(negedge clk);
    ctrl = make_word(2'd1, 2'd0, 2'd0, 1'b0);
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk); check("R9 after edge k",   int'(start_req), 0);
    @(negedge clk); check("R9 after edge k+1", int'(start_req), 0);
    @(negedge clk); check("R9 after edge k+2", int'(start_req), 1);
    @(negedge clk); check("R9 after edge k+3", int'(start_req), 0);

    // R5: trigger toggling every cycle, start on rising, clear on either
    ctrl = 32'h0;
    @(negedge clk);
    trig = 1'b0;
    repeat (5) @(negedge clk);
    ctrl = make_word(2'd1, 2'd0, 2'd3, 1'b0);
    cs = 0; cp = 0; cc = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cs += int'(start_req); cp += int'(stop_req); cc += int'(clear_req);
      trig = ~trig;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cs += int'(start_req); cp += int'(stop_req); cc += int'(clear_req);
    end
    check("R5 start per rising toggle", cs, 2);
    check("R5 stop stays off",          cp, 0);
    check("R5 clear per toggle",        cc, 4);

    // R7: reset asserted right as an edge arrives
    ctrl = make_word(2'd3, 2'd3, 2'd3, 1'b0);
    trig = 1'b0;
    repeat (6) @(negedge clk);
    trig  = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    count_pulses(10, cs, cp, cc);
    check("R7 start after mid reset", cs, 0);
    check("R7 stop after mid reset",  cp, 0);
    check("R7 clear after mid reset", cc, 0);

    summary();
  end

endmodule